// File: doc/BRIEF.md
# SMM Memory Window Decoder

This block sits in front of the memory controller and steers every memory access either to system DRAM or out to the legacy/PCI path. A processor can reach the 128 KB protected window through two address ranges: the low window at 0xA0000..0xBFFFF and a high alias at 0xFEDA0000..0xFEDBFFFF. The high alias lands on the same DRAM bytes as the low window. Two byte-wide configuration registers decide which range is backed by DRAM. They are written through a small config port at offsets 0x9D (window control) and 0x9E (extended window control). Each access also carries a flag that says whether the processor is in system management mode.

A request is decoded in one cycle. It returns a DRAM-hit strobe and the translated DRAM address. A hit in the high alias is moved down by 0xFED00000. Any access that is not a hit passes through unchanged. All window enables come from registered configuration state. A config write therefore switches the whole mapping at a single clock edge, and no request ever sees a half-updated view. The top-segment size field and the cache-attribute bits of the extended register are stored and read back only. They have no effect on the decode.

Top module: `smram_window_decoder`

## Requirements
- R1: After reset, offset 0x9D reads 0x02, offset 0x9E reads 0x00, and no response is valid.
- R2: At 0x9D, bits 6 (open), 5 (close) and 3 (global enable) are writable, bits 2:0 always read 010, and bits 7 and 4 read 0. At 0x9E, bits 7:1 are writable and bit 0 reads 0. Any other offset reads 0x00, and writes to it change neither register.
- R3: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and `rspDramHit` is only ever high together with `rspValid`.
- R4: An access outside both windows never hits, and any miss returns the request address unchanged.
- R5: For a non-SMM access with the open bit (0x9D bit 6) clear, neither window hits.
- R6: For a non-SMM access with the open bit set and the high-select bit (0x9E bit 7) clear, the low window hits at an unchanged address and the high window misses.
- R7: For a non-SMM access with the open bit set and high-select set, the low window misses and the high window hits at address minus 0xFED00000.
- R8: For an SMM access with global enable (0x9D bit 3) set, high-select alone chooses the DRAM-backed window (clear: low only, set: high only, remapped), whatever the open bit is.
- R9: For an SMM access with global enable clear, the decode equals the non-SMM decode.
- R10: A request in the same cycle as a config write decodes with the settings from before the write, and the next request decodes with the new settings.
- R11: The close bit, the top-segment size bits (0x9E bits 2:1) and the error/cache bits (0x9E bits 6:3) have no effect on any decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 8 | Config offset for read and write |
| cfgWrData | input | 8 | Config write data |
| cfgRdData | output | 8 | Config read data for `cfgAddr` (combinational) |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 32 | Access address |
| reqSmm | input | 1 | Access is made in system management mode |
| rspValid | output | 1 | Decode result valid, one cycle after the request |
| rspDramHit | output | 1 | Access is claimed by DRAM |
| rspDramAddr | output | 32 | Translated DRAM address, or the request address on a miss |

## Verification
The hardest case to reach is a request that lands in a window in the very cycle a config write flips the open, global-enable or high-select bit. The settings in force at that moment exist for only one edge. The random stimulus issues a write and a request together in a large share of cycles, with request addresses biased onto both windows and their edges. The bench model always decodes with the register values from before the write. Directed sequences also toggle each enable bit while hammering the same window address. Irrelevant bits are randomised alongside, to show that they have no effect.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam int ADDR_W     = 32;
  localparam int CFG_W      = 8;
  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000;
  localparam int WIN_BYTES  = 32'h0002_0000;
  localparam int WIN_SHIFT  = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] REMAP_OFF = HIGH_BASE - LOW_BASE;

  // window-control register layout
  localparam int CTL_OPEN_BIT   = 6;
  localparam int CTL_CLOSE_BIT  = 5;
  localparam int CTL_GLOBAL_BIT = 3;
  localparam logic [CFG_W-1:0] CTL_WMASK = 8'h68;
  localparam logic [CFG_W-1:0] CTL_FIXED = 8'h02;
  // extended register layout
  localparam int EXT_HIGHSEL_BIT = 7;
  localparam logic [CFG_W-1:0] EXT_WMASK = 8'hFE;

  // enable strobes from control to datapath
  typedef struct packed {
    logic smmLow;
    logic smmHigh;
    logic normLow;
    logic normHigh;
  } win_en_t;
endpackage

// File: rtl/smram_cfg_ctrl.sv
module smram_cfg_ctrl
  import smram_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h9D,
  parameter logic [CFG_AW-1:0] EXT_OFFSET = 8'h9E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [CFG_W-1:0]  cfgRdData,
  output win_en_t           winEn
);
  logic [CFG_W-1:0] ctlQ;
  logic [CFG_W-1:0] extQ;
  logic ctlSel, extSel;

  assign ctlSel = (cfgAddr == CTL_OFFSET);
  assign extSel = (cfgAddr == EXT_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
      extQ <= '0;
    end else if (cfgWrEn) begin
      if (ctlSel) ctlQ <= cfgWrData & CTL_WMASK;
      if (extSel) extQ <= cfgWrData & EXT_WMASK;
    end
  end

  always_comb begin
    cfgRdData = '0;
    if (ctlSel)      cfgRdData = ctlQ | CTL_FIXED;
    else if (extSel) cfgRdData = extQ;
  end

  // All enables derive from registered state: one edge switches them together.
  logic openQ, globalQ, highSelQ;
  assign openQ    = ctlQ[CTL_OPEN_BIT];
  assign globalQ  = ctlQ[CTL_GLOBAL_BIT];
  assign highSelQ = extQ[EXT_HIGHSEL_BIT];

  always_comb begin
    winEn.normLow  = openQ & ~highSelQ;
    winEn.normHigh = openQ &  highSelQ;
    winEn.smmLow   = globalQ ? ~highSelQ : winEn.normLow;
    winEn.smmHigh  = globalQ ?  highSelQ : winEn.normHigh;
  end
endmodule

// File: rtl/smram_decode_dp.sv
module smram_decode_dp
  import smram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  win_en_t           winEn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSmm,
  output logic              rspValid,
  output logic              rspDramHit,
  output logic [ADDR_W-1:0] rspDramAddr
);
  localparam int TAG_W = ADDR_W - WIN_SHIFT;
  localparam int NWIN  = 2;

  logic [NWIN-1:0] inWin;
  logic [NWIN-1:0] winOn;
  logic [ADDR_W-1:0] winBase [NWIN];

  assign winBase[0] = LOW_BASE;
  assign winBase[1] = HIGH_BASE;
  assign winOn[0]   = reqSmm ? winEn.smmLow  : winEn.normLow;
  assign winOn[1]   = reqSmm ? winEn.smmHigh : winEn.normHigh;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign inWin[w] = (reqAddr[ADDR_W-1:WIN_SHIFT] == winBase[w][ADDR_W-1:WIN_SHIFT]);
  end

  logic hitLow, hitHigh;
  logic [ADDR_W-1:0] nextAddr;
  assign hitLow   = inWin[0] & winOn[0];
  assign hitHigh  = inWin[1] & winOn[1];
  assign nextAddr = hitHigh ? (reqAddr - REMAP_OFF) : reqAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspDramHit  <= 1'b0;
      rspDramAddr <= '0;
    end else begin
      rspValid   <= reqValid;
      rspDramHit <= reqValid & (hitLow | hitHigh);
      if (reqValid) rspDramAddr <= nextAddr;
    end
  end
endmodule

// File: rtl/smram_window_decoder.sv
module smram_window_decoder
  import smram_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter logic [CFG_AW-1:0] CTL_OFFSET = 8'h9D,
  parameter logic [CFG_AW-1:0] EXT_OFFSET = 8'h9E
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqSmm,
  output logic              rspValid,
  output logic              rspDramHit,
  output logic [31:0]       rspDramAddr
);
  win_en_t winEn;

  smram_cfg_ctrl #(
    .CFG_AW(CFG_AW), .CTL_OFFSET(CTL_OFFSET), .EXT_OFFSET(EXT_OFFSET)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .winEn(winEn)
  );

  smram_decode_dp u_dp (
    .clk(clk), .rstN(rstN), .winEn(winEn), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .rspValid(rspValid),
    .rspDramHit(rspDramHit), .rspDramAddr(rspDramAddr)
  );
endmodule

// File: rtl/smram_window_checker.sv
module smram_window_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  cfgAddr,
  input logic [7:0]  cfgRdData,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        rspValid,
  input logic        rspDramHit,
  input logic [31:0] rspDramAddr
);
  logic reqOutside;
  assign reqOutside = (reqAddr[31:17] != 15'h0005) && (reqAddr[31:17] != 15'h7F6D);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R3
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R3
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rspDramHit |-> rspValid); // R3
  AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOutside) |=> !rspDramHit); // R4
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspDramHit || rspDramAddr == $past(reqAddr))); // R4
  AST_HIT_LANDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rspDramHit |-> (rspDramAddr[31:17] == 15'h0005)); // R7
  AST_FIXED_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAddr == 8'h9D) |-> (cfgRdData[2:0] == 3'b010)); // R2
endmodule

bind smram_window_decoder smram_window_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData),
  .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
  .rspDramHit(rspDramHit), .rspDramAddr(rspDramAddr)
);

// File: tb/smram_window_decoder_bench.sv
module smram_window_decoder_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgAddr = 8'h00;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = 32'h0;
  logic reqSmm = 1'b0;
  logic rspValid, rspDramHit;
  logic [31:0] rspDramAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] mCtl = 8'h02;
  logic [7:0] mExt = 8'h00;

  always #5 clk = ~clk;

  smram_window_decoder u_smram_window_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqSmm(reqSmm), .rspValid(rspValid),
    .rspDramHit(rspDramHit), .rspDramAddr(rspDramAddr)
  );

  function automatic logic [32:0] model(input logic [7:0] c, input logic [7:0] e,
                                        input logic [31:0] a, input logic sm);
    logic inLow, inHigh, en, hs, hit;
    inLow  = (a[31:17] == 15'h0005);
    inHigh = (a[31:17] == 15'h7F6D);
    hs  = e[7];
    en  = (sm && c[3]) || c[6];
    hit = en && (hs ? inHigh : inLow);
    return {hit, (hit && hs) ? a - 32'hFED0_0000 : a};
  endfunction

  function automatic string tagFor(input logic [7:0] c, input logic [31:0] a, input logic sm);
    if (a[31:17] != 15'h0005 && a[31:17] != 15'h7F6D) return "R4";
    if (sm && c[3]) return "R8";
    if (sm) return "R9";
    if (!c[6]) return "R5";
    return (mExt[7]) ? "R7" : "R6";
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let an edge pass, check at the next negedge.
  task automatic step(input bit we, input logic [7:0] ca, input logic [7:0] cd,
                      input bit rv, input logic [31:0] ra, input bit sm, input string tag);
    logic [32:0] exp;
    string t;
    cfgWrEn = we; cfgAddr = ca; cfgWrData = cd;
    reqValid = rv; reqAddr = ra; reqSmm = sm;
    exp = model(mCtl, mExt, ra, sm);
    t = (tag == "") ? tagFor(mCtl, ra, sm) : tag;
    @(posedge clk);
    @(negedge clk);
    check(rspValid == rv, "R3 valid", {63'd0, rspValid}, {63'd0, rv});
    if (rv) begin
      check(rspDramHit == exp[32], t, {63'd0, rspDramHit}, {63'd0, exp[32]});
      check(rspDramAddr == exp[31:0], t, {32'd0, rspDramAddr}, {32'd0, exp[31:0]});
    end else begin
      check(!rspDramHit, "R3 hit", {63'd0, rspDramHit}, 64'd0);
    end
    if (we && ca == 8'h9D) mCtl = (cd & 8'h68) | 8'h02;
    if (we && ca == 8'h9E) mExt = cd & 8'hFE;
    cfgWrEn = 1'b0; reqValid = 1'b0;
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cfgWrEn = 1'b0; cfgAddr = a;
    #1;
    check(cfgRdData == exp, tag, {56'd0, cfgRdData}, {56'd0, exp});
  endtask

  function automatic logic [31:0] pickAddr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 5))
      0: return 32'h000A_0000 | (r & 32'h1_FFFF);
      1: return 32'hFEDA_0000 | (r & 32'h1_FFFF);
      2: return 32'h0009_FFFF;
      3: return 32'h000C_0000;
      4: return ($urandom_range(0, 1) != 0) ? 32'hFED9_FFFF : 32'hFEDC_0000;
      default: return r;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    // R1 reset state
    rdCheck(8'h9D, 8'h02, "R1 ctl reset");
    rdCheck(8'h9E, 8'h00, "R1 ext reset");
    check(!rspValid, "R1 valid", {63'd0, rspValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 register access
    step(1, 8'h9D, 8'hFF, 0, 0, 0, "");
    rdCheck(8'h9D, 8'h6A, "R2 ctl mask");
    step(1, 8'h9E, 8'hFF, 0, 0, 0, "");
    rdCheck(8'h9E, 8'hFE, "R2 ext mask");
    step(1, 8'h9C, 8'h00, 0, 0, 0, "");
    step(1, 8'h9F, 8'h00, 0, 0, 0, "");
    rdCheck(8'h9D, 8'h6A, "R2 ctl untouched");
    rdCheck(8'h9E, 8'hFE, "R2 ext untouched");
    rdCheck(8'h9F, 8'h00, "R2 other offset");
    step(1, 8'h9D, 8'h00, 0, 0, 0, "");
    rdCheck(8'h9D, 8'h02, "R2 ctl cleared");
    step(1, 8'h9E, 8'h00, 0, 0, 0, "");

    // R5 closed, non-SMM
    step(0, 0, 0, 1, 32'h000A_1234, 0, "R5");
    step(0, 0, 0, 1, 32'hFEDA_1234, 0, "R5");
    // R6 open, low window
    step(1, 8'h9D, 8'h40, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'h000B_FFFF, 0, "R6");
    step(0, 0, 0, 1, 32'hFEDA_0000, 0, "R6");
    // R7 open, high window
    step(1, 8'h9E, 8'h80, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'hFEDB_FFFF, 0, "R7");
    step(0, 0, 0, 1, 32'h000A_0000, 0, "R7");
    // R8 SMM with global enable, open clear
    step(1, 8'h9D, 8'h08, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'hFEDA_0040, 1, "R8");
    step(0, 0, 0, 1, 32'h000A_0040, 1, "R8");
    step(1, 8'h9E, 8'h00, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'h000A_0040, 1, "R8");
    step(0, 0, 0, 1, 32'hFEDA_0040, 1, "R8");
    // R9 SMM without global enable
    step(1, 8'h9D, 8'h00, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'h000A_0040, 1, "R9");
    // R10 write and request together
    step(1, 8'h9D, 8'h40, 1, 32'h000A_0100, 0, "R10 old");
    step(0, 0, 0, 1, 32'h000A_0100, 0, "R10 new");
    step(1, 8'h9E, 8'h80, 1, 32'h000A_0100, 0, "R10 old");
    step(0, 0, 0, 1, 32'h000A_0100, 0, "R10 new");
    // R11 irrelevant bits
    step(1, 8'h9D, 8'h60, 0, 0, 0, "");
    step(1, 8'h9E, 8'hFE, 1, 32'hFEDA_0800, 0, "R11");
    step(0, 0, 0, 1, 32'hFEDA_0800, 0, "R11");
    step(1, 8'h9E, 8'h7E, 0, 0, 0, "");
    step(0, 0, 0, 1, 32'h000A_0800, 0, "R11");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit we;
      logic [7:0] ca;
      we = ($urandom_range(0, 2) == 0);
      ca = ($urandom_range(0, 5) == 0) ? 8'($urandom) : (($urandom_range(0, 1) != 0) ? 8'h9D : 8'h9E);
      step(we, ca, 8'($urandom), $urandom_range(0, 4) != 0, pickAddr(),
           $urandom_range(0, 1) != 0, "");
    end
    rdCheck(8'h9D, mCtl, "R2 final ctl");
    rdCheck(8'h9E, mExt, "R2 final ext");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule